// File: doc/BRIEF.md
# Software-Started A/D Conversion Sequencer

This block sequences single-shot conversions of an A/D converter under software control. Software writes three register-style fields: an enable bit, a start bit and a channel number. The block drives a start/abort interface to a converter core. The core is modelled here as a fixed-latency counter that returns a result word derived from the channel. When a conversion completes, the block captures the word in a result register, pulses an end-of-conversion interrupt, and clears the start bit by itself.

The block has three states: stopped, standby and converting. A write to the start bit or to the channel field during a conversion takes effect at once. Writing 1 to the start bit, or any channel write, aborts the running conversion and starts a fresh one. Writing 0 to the start bit aborts it and returns the block to standby. A hardware trigger input exists but is never honoured in this mode. Software should wait about 1 µs after enabling before it starts a conversion. The block does not enforce that wait.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the block is stopped: `en_o`, `go_o`, `busy_o` and `eoc_irq_o` are 0, `ch_o` is 0 and `result_o` is 0.
- R2: A write of 1 to the enable bit while stopped sets `en_o` and enters standby on the next cycle. A write of 0 to the enable bit in standby clears `en_o` and returns the block to stopped.
- R3: In standby, a write of 1 to the start bit sets `go_o` and `busy_o` from the cycle after the write. The conversion uses the channel value in force after that write cycle.
- R4: A conversion that runs undisturbed ends LAT cycles after the write that started it. In that cycle `eoc_irq_o` is high for exactly one cycle and `result_o` equals ((channel + 1) × 97) mod 2^RES_W.
- R5: In the cycle the interrupt is shown, `go_o` and `busy_o` are already 0 and the block is back in standby.
- R6: A write of 1 to the start bit during a conversion restarts it. The interrupt then comes LAT cycles after that write and not earlier.
- R7: A channel write during a conversion restarts it on the new channel. The result then reflects the new channel.
- R8: A write of 0 to the start bit during a conversion aborts it. `busy_o` and `go_o` drop on the next cycle, no interrupt follows, and `result_o` keeps its previous value.
- R9: While `en_o` is 0, a write of 1 to the start bit is ignored: `go_o` and `busy_o` stay 0.
- R10: `hw_trig_i` never starts a conversion, in either the stopped or the standby state.
- R11: A write of 0 to the enable bit during a conversion aborts it and goes straight to stopped, with no interrupt.
- R12: If a restart write lands in the cycle in which a conversion would complete, the restart wins. No interrupt is given and no result is stored for the discarded conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_wr_i | input | 1 | Write strobe for the enable bit |
| en_wdata_i | input | 1 | Value written to the enable bit |
| go_wr_i | input | 1 | Write strobe for the start bit |
| go_wdata_i | input | 1 | Value written to the start bit |
| ch_wr_i | input | 1 | Write strobe for the channel field |
| ch_wdata_i | input | CH_W | Value written to the channel field |
| hw_trig_i | input | 1 | Hardware trigger, ignored in this mode |
| en_o | output | 1 | Enable bit readback |
| go_o | output | 1 | Start bit readback, self-clearing |
| ch_o | output | CH_W | Channel field readback |
| busy_o | output | 1 | Conversion in progress |
| result_o | output | RES_W | Last completed conversion result |
| eoc_irq_o | output | 1 | One-cycle end-of-conversion interrupt |

## Verification
The assertions assume that every write strobe is a clean single-cycle pulse sampled at the clock edge. They also assume that the write data is meaningful only while its strobe is high, and that simultaneous writes to different fields resolve by the fixed priority: enable clear, then start clear, then restart. The random stimulus keeps to that contract. It drives each strobe for one cycle from the falling edge, keeps strobe rates low so that many conversions run to completion, and toggles the hardware trigger freely, since it must have no effect.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_STOP    = 2'd0,
        ST_STANDBY = 2'd1,
        ST_CONV    = 2'd2
    } seq_state_e;

endpackage

// File: rtl/adc_seq_core.sv
module adc_seq_core #(
    parameter int CH_W  = 3,
    parameter int RES_W = 12,
    parameter int LAT   = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             abort_i,
    input  logic [CH_W-1:0]  ch_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);
    localparam int CNT_W = $clog2(LAT + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [CH_W-1:0]  ch;
    } core_s;

    core_s core_d, core_q;

    always_comb begin
        core_d = core_q;
        if (start_i) begin
            core_d.busy = 1'b1;
            core_d.cnt  = CNT_W'(LAT - 1);
            core_d.ch   = ch_i;
        end else if (abort_i) begin
            core_d.busy = 1'b0;
        end else if (core_q.busy) begin
            if (core_q.cnt == '0) core_d.busy = 1'b0;
            else                  core_d.cnt  = core_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) core_q <= '0;
        else         core_q <= core_d;
    end

    assign busy_o   = core_q.busy;
    assign done_o   = core_q.busy && (core_q.cnt == '0);
    assign result_o = RES_W'((32'(core_q.ch) + 32'd1) * 32'd97);

    AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_q.busy |-> (core_q.cnt <= CNT_W'(LAT - 1)));  // R4

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CH_W  = 3,
    parameter int RES_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_wr_i,
    input  logic             en_wdata_i,
    input  logic             go_wr_i,
    input  logic             go_wdata_i,
    input  logic             ch_wr_i,
    input  logic [CH_W-1:0]  ch_wdata_i,
    input  logic             hw_trig_i,
    input  logic             core_done_i,
    input  logic [RES_W-1:0] core_result_i,
    output logic             core_start_o,
    output logic             core_abort_o,
    output logic [CH_W-1:0]  core_ch_o,
    output logic             en_o,
    output logic             go_o,
    output logic [CH_W-1:0]  ch_o,
    output logic             busy_o,
    output logic [RES_W-1:0] result_o,
    output logic             irq_o
);
    typedef struct packed {
        seq_state_e       state;
        logic             en;
        logic             go;
        logic [CH_W-1:0]  ch;
        logic [RES_W-1:0] result;
        logic             irq;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;

    logic en_clr, go_set, go_clr;
    assign en_clr = en_wr_i && !en_wdata_i;
    assign go_set = go_wr_i && go_wdata_i;
    assign go_clr = go_wr_i && !go_wdata_i;

    always_comb begin
        ctrl_d       = ctrl_q;
        ctrl_d.irq   = 1'b0;
        core_start_o = 1'b0;
        core_abort_o = 1'b0;
        if (ch_wr_i) ctrl_d.ch = ch_wdata_i;
        unique case (ctrl_q.state)
            ST_STOP: begin
                if (en_wr_i && en_wdata_i) begin
                    ctrl_d.state = ST_STANDBY;
                    ctrl_d.en    = 1'b1;
                end
            end
            ST_STANDBY: begin
                if (en_clr) begin
                    ctrl_d.state = ST_STOP;
                    ctrl_d.en    = 1'b0;
                end else if (go_set) begin
                    ctrl_d.state = ST_CONV;
                    ctrl_d.go    = 1'b1;
                    core_start_o = 1'b1;
                end
            end
            ST_CONV: begin
                if (en_clr) begin
                    ctrl_d.state = ST_STOP;
                    ctrl_d.en    = 1'b0;
                    ctrl_d.go    = 1'b0;
                    core_abort_o = 1'b1;
                end else if (go_clr) begin
                    ctrl_d.state = ST_STANDBY;
                    ctrl_d.go    = 1'b0;
                    core_abort_o = 1'b1;
                end else if (go_set || ch_wr_i) begin
                    core_start_o = 1'b1;
                end else if (core_done_i) begin
                    ctrl_d.state  = ST_STANDBY;
                    ctrl_d.go     = 1'b0;
                    ctrl_d.result = core_result_i;
                    ctrl_d.irq    = 1'b1;
                end
            end
            default: ctrl_d = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) ctrl_q <= '0;
        else         ctrl_q <= ctrl_d;
    end

    assign core_ch_o = ctrl_d.ch;
    assign en_o      = ctrl_q.en;
    assign go_o      = ctrl_q.go;
    assign ch_o      = ctrl_q.ch;
    assign busy_o    = (ctrl_q.state == ST_CONV);
    assign result_o  = ctrl_q.result;
    assign irq_o     = ctrl_q.irq;

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_q.irq |=> !ctrl_q.irq);  // R4
    AST_GO_AUTO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ctrl_q.irq) |-> $fell(ctrl_q.go));  // R5
    AST_GO_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_q.en |-> !ctrl_q.go);  // R9
    AST_NO_HW_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hw_trig_i && ctrl_q.state != ST_CONV && !go_set) |=> ctrl_q.state != ST_CONV);  // R10
    AST_RESULT_ONLY_ON_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(ctrl_q.result) |-> ctrl_q.irq);  // R8

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
    parameter int CH_W  = 3,
    parameter int RES_W = 12,
    parameter int LAT   = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_wr_i,
    input  logic             en_wdata_i,
    input  logic             go_wr_i,
    input  logic             go_wdata_i,
    input  logic             ch_wr_i,
    input  logic [CH_W-1:0]  ch_wdata_i,
    input  logic             hw_trig_i,
    output logic             en_o,
    output logic             go_o,
    output logic [CH_W-1:0]  ch_o,
    output logic             busy_o,
    output logic [RES_W-1:0] result_o,
    output logic             eoc_irq_o
);
    logic             core_start, core_abort, core_busy, core_done;
    logic [CH_W-1:0]  core_ch;
    logic [RES_W-1:0] core_result;

    adc_seq_ctrl #(.CH_W(CH_W), .RES_W(RES_W)) ctrl_i (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .en_wr_i       (en_wr_i),
        .en_wdata_i    (en_wdata_i),
        .go_wr_i       (go_wr_i),
        .go_wdata_i    (go_wdata_i),
        .ch_wr_i       (ch_wr_i),
        .ch_wdata_i    (ch_wdata_i),
        .hw_trig_i     (hw_trig_i),
        .core_done_i   (core_done),
        .core_result_i (core_result),
        .core_start_o  (core_start),
        .core_abort_o  (core_abort),
        .core_ch_o     (core_ch),
        .en_o          (en_o),
        .go_o          (go_o),
        .ch_o          (ch_o),
        .busy_o        (busy_o),
        .result_o      (result_o),
        .irq_o         (eoc_irq_o)
    );

    adc_seq_core #(.CH_W(CH_W), .RES_W(RES_W), .LAT(LAT)) core_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (core_start),
        .abort_i  (core_abort),
        .ch_i     (core_ch),
        .busy_o   (core_busy),
        .done_o   (core_done),
        .result_o (core_result)
    );

    AST_CORE_TRACKS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o == core_busy);  // R3
    AST_NO_IRQ_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eoc_irq_o |-> en_o);  // R11

endmodule

// File: tb/adc_seq_top_tb_top.sv
module adc_seq_top_tb_top;
    localparam int CH_W  = 3;
    localparam int RES_W = 12;
    localparam int LAT   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_wr = 0, en_wd = 0, go_wr = 0, go_wd = 0, ch_wr = 0, hw_trig = 0;
    logic [CH_W-1:0] ch_wd = '0;
    logic en_o, go_o, busy_o, irq_o;
    logic [CH_W-1:0]  ch_o;
    logic [RES_W-1:0] result_o;

    int n_chk = 0, n_fail = 0;
    bit cmp_on = 0;
    bit done = 0;

    always #5 clk = ~clk;

    adc_seq_top #(.CH_W(CH_W), .RES_W(RES_W), .LAT(LAT)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .en_wr_i(en_wr), .en_wdata_i(en_wd),
        .go_wr_i(go_wr), .go_wdata_i(go_wd),
        .ch_wr_i(ch_wr), .ch_wdata_i(ch_wd),
        .hw_trig_i(hw_trig),
        .en_o(en_o), .go_o(go_o), .ch_o(ch_o), .busy_o(busy_o),
        .result_o(result_o), .eoc_irq_o(irq_o)
    );

    function automatic logic [RES_W-1:0] exp_word(input logic [CH_W-1:0] c);
        int v;
        v = (int'(c) + 1) * 97;
        return RES_W'(v % (1 << RES_W));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // requirement-level reference model: 0 stop, 1 standby, 2 converting
    int m_st = 0, m_rem = 0;
    logic m_en = 0, m_go = 0, m_irq = 0;
    logic [CH_W-1:0]  m_ch = '0, m_run = '0;
    logic [RES_W-1:0] m_res = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_rem = 0; m_en = 0; m_go = 0; m_irq = 0;
            m_ch = '0; m_run = '0; m_res = '0;
        end else begin
            m_irq = 0;
            if (ch_wr) m_ch = ch_wd;
            if (m_st == 0) begin
                if (en_wr && en_wd) begin m_st = 1; m_en = 1; end
            end else if (m_st == 1) begin
                if (en_wr && !en_wd) begin m_st = 0; m_en = 0; end
                else if (go_wr && go_wd) begin m_st = 2; m_go = 1; m_rem = LAT; m_run = m_ch; end
            end else begin
                if (en_wr && !en_wd) begin m_st = 0; m_en = 0; m_go = 0; end
                else if (go_wr && !go_wd) begin m_st = 1; m_go = 0; end
                else if ((go_wr && go_wd) || ch_wr) begin m_rem = LAT; m_run = m_ch; end
                else if (m_rem == 1) begin
                    m_st = 1; m_go = 0; m_irq = 1; m_res = exp_word(m_run);
                end else m_rem--;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R2 model en",      int'(en_o),     int'(m_en));
            chk("R3 model busy",    int'(busy_o),   int'(m_st == 2));
            chk("R4 model irq",     int'(irq_o),    int'(m_irq));
            chk("R4 model result",  int'(result_o), int'(m_res));
            chk("R5 model go",      int'(go_o),     int'(m_go));
            chk("R7 model ch",      int'(ch_o),     int'(m_ch));
        end
    end

    task automatic wr_en(input logic v);
        @(negedge clk); en_wr = 1; en_wd = v;
        @(negedge clk); en_wr = 0;
    endtask
    task automatic wr_go(input logic v);
        @(negedge clk); go_wr = 1; go_wd = v;
        @(negedge clk); go_wr = 0;
    endtask
    task automatic wr_ch(input logic [CH_W-1:0] v);
        @(negedge clk); ch_wr = 1; ch_wd = v;
        @(negedge clk); ch_wr = 0;
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #1_500_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [RES_W-1:0] keep;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 en", int'(en_o), 0);  chk("R1 go", int'(go_o), 0);
        chk("R1 busy", int'(busy_o), 0); chk("R1 irq", int'(irq_o), 0);
        chk("R1 ch", int'(ch_o), 0);  chk("R1 result", int'(result_o), 0);
        cmp_on = 1;

        // R10 / R9 while stopped
        hw_trig = 1;
        repeat (4) @(negedge clk);
        chk("R10 stopped trigger", int'(busy_o), 0);
        wr_go(1);
        chk("R9 go ignored", int'(go_o), 0);
        chk("R9 no busy", int'(busy_o), 0);

        // R2 enable
        wr_en(1);
        chk("R2 enabled", int'(en_o), 1);
        repeat (5) @(negedge clk);
        chk("R10 standby trigger", int'(busy_o), 0);
        hw_trig = 0;

        // R3 R4 R5 basic conversion
        wr_ch(3'd2);
        wr_go(1);
        chk("R3 busy", int'(busy_o), 1);
        chk("R3 go", int'(go_o), 1);
        for (int i = 0; i < LAT - 1; i++) begin
            @(negedge clk);
            chk("R4 no early irq", int'(irq_o), 0);
        end
        @(negedge clk);
        chk("R4 irq", int'(irq_o), 1);
        chk("R4 result", int'(result_o), int'(exp_word(3'd2)));
        chk("R5 go cleared", int'(go_o), 0);
        chk("R5 idle", int'(busy_o), 0);
        @(negedge clk);
        chk("R4 irq single", int'(irq_o), 0);

        // R6 restart
        wr_go(1);
        repeat (5) @(negedge clk);
        wr_go(1);
        for (int i = 0; i < LAT - 1; i++) begin
            @(negedge clk);
            chk("R6 no early irq", int'(irq_o), 0);
        end
        @(negedge clk);
        chk("R6 irq after restart", int'(irq_o), 1);

        // R7 channel change
        wr_go(1);
        repeat (3) @(negedge clk);
        wr_ch(3'd5);
        chk("R7 still busy", int'(busy_o), 1);
        repeat (LAT - 1) @(negedge clk);
        chk("R7 no early irq", int'(irq_o), 0);
        @(negedge clk);
        chk("R7 irq", int'(irq_o), 1);
        chk("R7 result new ch", int'(result_o), int'(exp_word(3'd5)));

        // R8 abort by start clear
        keep = result_o;
        wr_go(1);
        repeat (4) @(negedge clk);
        wr_go(0);
        chk("R8 busy dropped", int'(busy_o), 0);
        chk("R8 go dropped", int'(go_o), 0);
        for (int i = 0; i < LAT + 2; i++) begin
            @(negedge clk);
            chk("R8 no irq", int'(irq_o), 0);
        end
        chk("R8 result kept", int'(result_o), int'(keep));

        // R11 enable clear during conversion
        wr_go(1);
        repeat (2) @(negedge clk);
        wr_en(0);
        chk("R11 stopped", int'(en_o), 0);
        chk("R11 not busy", int'(busy_o), 0);
        chk("R11 go clear", int'(go_o), 0);
        for (int i = 0; i < LAT; i++) begin
            @(negedge clk);
            chk("R11 no irq", int'(irq_o), 0);
        end

        // R12 restart in the completing cycle
        wr_en(1);
        wr_go(1);
        repeat (LAT - 2) @(negedge clk);
        wr_go(1);
        chk("R12 no irq", int'(irq_o), 0);
        chk("R12 still busy", int'(busy_o), 1);
        repeat (LAT - 1) @(negedge clk);
        chk("R12 no early irq", int'(irq_o), 0);
        @(negedge clk);
        chk("R12 irq later", int'(irq_o), 1);

        // random phase, checked by the model every cycle
        void'($urandom(32'h5eed_1234));
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            en_wr   = ($urandom % 40) == 0;
            en_wd   = ($urandom % 4) != 0;
            go_wr   = ($urandom % 25) == 0;
            go_wd   = ($urandom % 4) != 0;
            ch_wr   = ($urandom % 30) == 0;
            ch_wd   = CH_W'($urandom);
            hw_trig = ($urandom % 4) == 0;
        end
        @(negedge clk);
        en_wr = 0; go_wr = 0; ch_wr = 0; hw_trig = 0;
        repeat (LAT + 2) @(negedge clk);
        summary();
    end
endmodule